// File: doc/BRIEF.md
# Dual-Channel Timer Input Capture

This block holds a 16-bit free-running counter, advanced at a rate set by a 2-bit clock divider select. Each of the two capture channels watches its own input pin through a two-flop synchronizer. On the edge that channel is set to detect, it latches the current counter value into a read-only capture register. The capture resolution is one counter tick. A CPU with an 8-bit data bus reads each capture register as a high byte and a low byte. It also reads a status register that holds one capture flag per channel.

The channel flags are combined into one timer interrupt request through three kinds of enable. A global enable gates everything. A shared enable, when set, lets any channel interrupt and ignores the per-channel enables. When the shared enable is clear, each channel needs its own enable. A flag is cleared only by a two-step access: first any access to the status register, then any access to that channel's low byte.

Reading a high byte locks that channel's capture register until the low byte is read, so that the two bytes always come from the same capture. A capture that arrives while the register is locked is held in a shadow register. It moves into the capture register when the low byte is read, so the most recent value is never lost.

Top module: `dual_capture_timer`

## Requirements
- R1: An active edge on a channel pin latches the counter into that channel's capture register. The latched value is the counter value present just after the second rising clock edge following the pin change. The register becomes readable one edge later. The bus select codes are: 1 = channel 0 high byte, 2 = channel 0 low byte, 3 = channel 1 high byte, 4 = channel 1 low byte. The value of `rd_data` follows `acc_sel` combinationally.
- R2: Each channel's `edge_sel` bit chooses the active edge: 1 selects rising, 0 selects falling. An edge of the other polarity captures nothing and leaves the flag unchanged.
- R3: `clk_div_sel` sets the counter rate: 00 advances the counter once per 4 clocks, 01 once per 2 clocks, 10 once per 8 clocks, and 11 stops the counter. After n clocks out of reset at divide d, the counter equals floor(n/d).
- R4: A capture sets that channel's flag. Select code 0 reads the status register, which shows channel 0's flag in bit 0 and channel 1's flag in bit 1. After reset, all flags are zero and `irq` is low.
- R5: When `ie_global` and `ie_shared` are both 1, `irq` is high whenever any flag is set, whatever the value of `ie_ch`.
- R6: When `ie_shared` is 0, a channel drives `irq` only if its own `ie_ch` bit and `ie_global` are set. When `ie_global` is 0, `irq` is low.
- R7: A flag set while its enables are off keeps the request pending. `irq` rises as soon as the enables allow it.
- R8: A flag clears only after an access (read or write) to the status register is followed by an access (read or write) to that channel's low byte. A low-byte access without the earlier status access leaves the flag set.
- R9: After a channel's high byte is read, its capture register does not change until its low byte is read. The low byte then returns the value from the same capture as the high byte.
- R10: Captures made while a channel is locked are kept in a shadow register, and the latest one overwrites any earlier one. That value moves into the capture register when the low byte is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_pin | input | 2 | Capture input pins, one per channel |
| edge_sel | input | 2 | Active-edge select per channel (1 rising) |
| clk_div_sel | input | 2 | Counter rate select |
| ie_global | input | 1 | Global timer interrupt enable |
| ie_shared | input | 1 | Shared capture interrupt enable |
| ie_ch | input | 2 | Per-channel capture interrupt enables |
| acc_en | input | 1 | Bus access strobe, one cycle per access |
| acc_wr | input | 1 | Access is a write (data ignored) |
| acc_sel | input | 3 | Register select code |
| rd_data | output | 8 | Read data for the selected register |
| cap_flag | output | 2 | Capture flags |
| irq | output | 1 | Timer interrupt request |

## Verification
A pin change made at a falling clock edge is synchronized over the next two rising edges. The counter value just after the second edge is the value that gets captured, and the flag and capture register update on the third edge. The bench therefore records its expected value 1 ns after that second edge, computing it from its own count of cycles since reset, and reads back only after two more falling edges. Bus reads are sampled 1 ns after the falling edge on which the select is driven. The lock, unlock and flag-clear side effects of an access take hold at the following rising edge, before the next access starts. `irq` is combinational from the flags and enables, so it is checked in the same cycle the enables change.

// File: rtl/dct_pkg.sv
`timescale 1ns/1ps
package dct_pkg;
   typedef enum logic [1:0] {
      DIV_BY4  = 2'b00,
      DIV_BY2  = 2'b01,
      DIV_BY8  = 2'b10,
      DIV_STOP = 2'b11
   } div_sel_e;

   localparam int PRE_W = 3;

   function automatic logic [PRE_W-1:0] div_limit(input div_sel_e s);
      case (s)
         DIV_BY4: return PRE_W'(3);
         DIV_BY2: return PRE_W'(1);
         DIV_BY8: return PRE_W'(7);
         default: return '0;
      endcase
   endfunction
endpackage

// File: rtl/dct_prescaler.sv
`timescale 1ns/1ps
module dct_prescaler
   import dct_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       div_sel,
   output logic [CNT_W-1:0] count
);
   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] lim;
   logic             halted;

   always_comb begin
      lim    = div_limit(div_sel_e'(div_sel));
      halted = (div_sel_e'(div_sel) == DIV_STOP);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre_q <= '0;
         count <= '0;
      end else if (!halted) begin
         if (pre_q >= lim) begin
            pre_q <= '0;
            count <= count + 1'b1;
         end else begin
            pre_q <= pre_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/dct_edge_sync.sv
`timescale 1ns/1ps
module dct_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic rise_sel,
   output logic hit
);
   logic [STAGES-1:0] sh_q;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dct_edge_sync needs at least two synchronizer stages");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q   <= '0;
         prev_q <= 1'b0;
      end else begin
         sh_q   <= {sh_q[STAGES-2:0], pin};
         prev_q <= sh_q[STAGES-1];
      end
   end

   always_comb begin
      if (rise_sel) hit = sh_q[STAGES-1] & ~prev_q;
      else          hit = ~sh_q[STAGES-1] & prev_q;
   end
endmodule

// File: rtl/dct_capture_chan.sv
`timescale 1ns/1ps
module dct_capture_chan #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit,
   input  logic [CNT_W-1:0] count,
   input  logic             stat_acc,
   input  logic             hi_rd,
   input  logic             lo_acc,
   input  logic             lo_rd,
   output logic             flag,
   output logic [CNT_W-1:0] cap
);
   logic             armed_q;
   logic             locked_q;
   logic             pend_q;
   logic [CNT_W-1:0] shadow_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap      <= '0;
         shadow_q <= '0;
         pend_q   <= 1'b0;
         locked_q <= 1'b0;
      end else begin
         if (hit) begin
            if (locked_q && !lo_rd) begin
               shadow_q <= count;
               pend_q   <= 1'b1;
            end else begin
               cap      <= count;
               pend_q   <= 1'b0;
            end
         end else if (lo_rd && pend_q) begin
            cap    <= shadow_q;
            pend_q <= 1'b0;
         end
         if (lo_rd)      locked_q <= 1'b0;
         else if (hi_rd) locked_q <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag    <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         if (hit)                    flag <= 1'b1;
         else if (lo_acc && armed_q) flag <= 1'b0;
         if (lo_acc && armed_q)      armed_q <= 1'b0;
         else if (stat_acc && flag)  armed_q <= 1'b1;
      end
   end
endmodule

// File: rtl/dual_capture_timer.sv
`timescale 1ns/1ps
module dual_capture_timer #(
   parameter int CNT_W       = 16,
   parameter int BUS_W       = 8,
   parameter int NUM_CH      = 2,
   parameter int SYNC_STAGES = 2,
   parameter int SEL_W       = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] cap_pin,
   input  logic [NUM_CH-1:0] edge_sel,
   input  logic [1:0]        clk_div_sel,
   input  logic              ie_global,
   input  logic              ie_shared,
   input  logic [NUM_CH-1:0] ie_ch,
   input  logic              acc_en,
   input  logic              acc_wr,
   input  logic [SEL_W-1:0]  acc_sel,
   output logic [BUS_W-1:0]  rd_data,
   output logic [NUM_CH-1:0] cap_flag,
   output logic              irq
);
   localparam int N_SEL = 2 * NUM_CH + 1;
   localparam logic [SEL_W-1:0] SEL_STAT = '0;

   generate
      if (CNT_W != 2 * BUS_W) begin : g_bad_width
         $error("capture width must be two bus bytes");
      end
      if (NUM_CH > BUS_W) begin : g_bad_ch
         $error("status register too narrow for channel count");
      end
      if ((1 << SEL_W) < N_SEL) begin : g_bad_sel
         $error("select field too narrow");
      end
   endgenerate

   logic [CNT_W-1:0]             count;
   logic [NUM_CH-1:0][CNT_W-1:0] cap_val;
   logic                         stat_acc;

   assign stat_acc = acc_en && (acc_sel == SEL_STAT);

   dct_prescaler #(.CNT_W(CNT_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .div_sel(clk_div_sel), .count(count)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      localparam logic [SEL_W-1:0] SEL_HI = SEL_W'(2 * g + 1);
      localparam logic [SEL_W-1:0] SEL_LO = SEL_W'(2 * g + 2);
      logic hit;
      logic hi_rd, lo_acc, lo_rd;

      assign hi_rd  = acc_en && !acc_wr && (acc_sel == SEL_HI);
      assign lo_acc = acc_en && (acc_sel == SEL_LO);
      assign lo_rd  = lo_acc && !acc_wr;

      dct_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk(clk), .rst_n(rst_n), .pin(cap_pin[g]),
         .rise_sel(edge_sel[g]), .hit(hit)
      );

      dct_capture_chan #(.CNT_W(CNT_W)) u_chan (
         .clk(clk), .rst_n(rst_n), .hit(hit), .count(count),
         .stat_acc(stat_acc), .hi_rd(hi_rd), .lo_acc(lo_acc), .lo_rd(lo_rd),
         .flag(cap_flag[g]), .cap(cap_val[g])
      );
   end

   always_comb begin
      rd_data = '0;
      if (acc_sel == SEL_STAT) rd_data[NUM_CH-1:0] = cap_flag;
      for (int i = 0; i < NUM_CH; i++) begin
         if (acc_sel == SEL_W'(2 * i + 1)) rd_data = cap_val[i][CNT_W-1:BUS_W];
         if (acc_sel == SEL_W'(2 * i + 2)) rd_data = cap_val[i][BUS_W-1:0];
      end
   end

   logic [NUM_CH-1:0] req_vec;
   always_comb begin
      req_vec = ie_shared ? cap_flag : (cap_flag & ie_ch);
      irq     = ie_global && (|req_vec);
   end
endmodule

// File: rtl/dct_checker.sv
`timescale 1ns/1ps
module dct_checker #(
   parameter int CNT_W  = 16,
   parameter int NUM_CH = 2,
   parameter int SEL_W  = 3
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         acc_en,
   input logic                         acc_wr,
   input logic [SEL_W-1:0]             acc_sel,
   input logic                         ie_global,
   input logic                         ie_shared,
   input logic [NUM_CH-1:0]            ie_ch,
   input logic [NUM_CH-1:0]            cap_flag,
   input logic                         irq,
   input logic [NUM_CH-1:0][CNT_W-1:0] cap_val
);
   assert_shared_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ie_global && ie_shared && (|cap_flag)) |-> irq);

   assert_global_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ie_global |-> !irq);

   assert_per_ch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ie_shared && ((cap_flag & ie_ch) == '0)) |-> !irq);

   for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
      localparam logic [SEL_W-1:0] HI = SEL_W'(2 * g + 1);
      localparam logic [SEL_W-1:0] LO = SEL_W'(2 * g + 2);
      logic lock_q;
      always_ff @(posedge clk) begin
         if (!rst_n) lock_q <= 1'b0;
         else if (acc_en && !acc_wr && acc_sel == LO) lock_q <= 1'b0;
         else if (acc_en && !acc_wr && acc_sel == HI) lock_q <= 1'b1;
      end

      assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(cap_flag[g]) |-> $past(acc_en && acc_sel == LO));

      assert_lock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (lock_q && !(acc_en && !acc_wr && acc_sel == LO)) |=> $stable(cap_val[g]));
   end
endmodule

bind dual_capture_timer dct_checker #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_sel(acc_sel),
   .ie_global(ie_global), .ie_shared(ie_shared), .ie_ch(ie_ch),
   .cap_flag(cap_flag), .irq(irq), .cap_val(cap_val)
);

// File: tb/dual_capture_timer_bench.sv
`timescale 1ns/1ps
module dual_capture_timer_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cap_pin = '0;
   logic [1:0] edge_sel = '0;
   logic [1:0] clk_div_sel = '0;
   logic       ie_global = 1'b0;
   logic       ie_shared = 1'b0;
   logic [1:0] ie_ch = '0;
   logic       acc_en = 1'b0;
   logic       acc_wr = 1'b0;
   logic [2:0] acc_sel = '0;
   logic [7:0] rd_data;
   logic [1:0] cap_flag;
   logic       irq;

   dual_capture_timer u_dual_capture_timer (
      .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .edge_sel(edge_sel),
      .clk_div_sel(clk_div_sel), .ie_global(ie_global), .ie_shared(ie_shared),
      .ie_ch(ie_ch), .acc_en(acc_en), .acc_wr(acc_wr), .acc_sel(acc_sel),
      .rd_data(rd_data), .cap_flag(cap_flag), .irq(irq)
   );

   always #2.5 clk = ~clk;

   int n_cyc = 0;
   int div_d = 4;
   int n_chk = 0;
   int n_err = 0;
   logic [15:0] exp_q[$];

   always @(posedge clk) n_cyc <= rst_n ? n_cyc + 1 : 0;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic bus(input logic [2:0] sel, input logic wr, output logic [7:0] d);
      @(negedge clk);
      acc_en = 1'b1; acc_sel = sel; acc_wr = wr;
      #1 d = rd_data;
      @(negedge clk);
      acc_en = 1'b0; acc_wr = 1'b0;
   endtask

   task automatic reset_to(input logic [1:0] dsel, input int d);
      @(negedge clk);
      rst_n = 1'b0; cap_pin = '0; clk_div_sel = dsel; div_d = d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // driver: change a pin, push the expected captured counter value
   task automatic drive_edge(input int ch, input logic lvl, input bit push);
      int v;
      @(negedge clk);
      cap_pin[ch] = lvl;
      @(posedge clk); @(posedge clk); #1;
      v = (div_d == 0) ? 0 : (n_cyc / div_d);
      if (push) exp_q.push_back(v[15:0]);
      repeat (2) @(negedge clk);
   endtask

   // monitor: read a capture register and compare with the scoreboard
   task automatic read_cap(input int ch, input string req);
      logic [7:0] hi, lo;
      logic [15:0] e;
      bus(3'(2 * ch + 1), 1'b0, hi);
      bus(3'(2 * ch + 2), 1'b0, lo);
      if (exp_q.size() == 0) begin
         n_chk++; n_err++;
         $display("FAIL %s: actual %0d expected none (scoreboard empty)", req, {hi, lo});
      end else begin
         e = exp_q.pop_front();
         chk(req, int'({hi, lo}), int'(e));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [7:0] d, hi1, lo1;
      logic [15:0] e;
      reset_to(2'b00, 4);
      #1 chk("R4 reset flags", int'(cap_flag), 0);
      chk("R4 reset irq", int'(irq), 0);
      bus(3'd0, 1'b0, d);
      chk("R4 reset status", int'(d), 0);

      // R1 rising capture on channel 0
      edge_sel = 2'b01;
      repeat (10) @(negedge clk);
      drive_edge(0, 1'b1, 1'b1);
      read_cap(0, "R1 ch0 rising value");
      bus(3'd0, 1'b0, d);
      chk("R8 lo alone keeps flag / R4 flag set", int'(d[0]), 1);
      bus(3'd2, 1'b0, d);
      bus(3'd0, 1'b0, d);
      chk("R8 status then lo clears flag", int'(d[0]), 0);

      // R2 falling select on channel 1
      drive_edge(1, 1'b1, 1'b0);
      bus(3'd0, 1'b0, d);
      chk("R2 rising ignored with falling select", int'(d[1]), 0);
      drive_edge(1, 1'b0, 1'b1);
      read_cap(1, "R2 ch1 falling value");
      chk("R2 flag after falling edge", int'(cap_flag[1]), 1);
      bus(3'd0, 1'b1, d);
      bus(3'd4, 1'b1, d);
      #1 chk("R8 write accesses clear flag", int'(cap_flag[1]), 0);

      // interrupt enables
      drive_edge(0, 1'b0, 1'b0);
      drive_edge(0, 1'b1, 1'b1);
      chk("R7 pending with enables off", int'(irq), 0);
      ie_global = 1'b1; #1;
      chk("R6 global only", int'(irq), 0);
      ie_ch = 2'b10; #1;
      chk("R6 other channel enable", int'(irq), 0);
      ie_ch = 2'b01; #1;
      chk("R7 fires once enabled", int'(irq), 1);
      ie_ch = 2'b00; ie_shared = 1'b1; #1;
      chk("R5 shared overrides per-channel", int'(irq), 1);
      bus(3'd0, 1'b0, d);
      read_cap(0, "R1 ch0 second value");
      #1 chk("R5 no flags no irq", int'(irq), 0);
      drive_edge(1, 1'b1, 1'b0);
      drive_edge(1, 1'b0, 1'b1);
      chk("R5 shared enables channel 1", int'(irq), 1);
      ie_shared = 1'b0; ie_ch = 2'b01; #1;
      chk("R6 ch1 not enabled", int'(irq), 0);
      ie_ch = 2'b11; #1;
      chk("R6 both per-channel enables", int'(irq), 1);
      ie_global = 1'b0; #1;
      chk("R6 global off", int'(irq), 0);
      bus(3'd0, 1'b0, d);
      read_cap(1, "R2 ch1 second value");

      // R9/R10 lock and shadow
      drive_edge(0, 1'b0, 1'b0);
      drive_edge(0, 1'b1, 1'b1);
      bus(3'd1, 1'b0, hi1);
      drive_edge(0, 1'b0, 1'b0);
      repeat (5) @(negedge clk);
      drive_edge(0, 1'b1, 1'b1);
      drive_edge(0, 1'b0, 1'b0);
      repeat (7) @(negedge clk);
      drive_edge(0, 1'b1, 1'b1);
      bus(3'd2, 1'b0, lo1);
      e = exp_q.pop_front();
      chk("R9 bytes from one capture", int'({hi1, lo1}), int'(e));
      void'(exp_q.pop_front());
      read_cap(0, "R10 latest shadowed capture");

      // R3 divider settings
      reset_to(2'b01, 2);
      repeat (600) @(negedge clk);
      drive_edge(0, 1'b1, 1'b1);
      read_cap(0, "R3 divide by 2");
      reset_to(2'b10, 8);
      repeat (40) @(negedge clk);
      drive_edge(0, 1'b1, 1'b1);
      read_cap(0, "R3 divide by 8");
      reset_to(2'b11, 0);
      repeat (50) @(negedge clk);
      drive_edge(0, 1'b1, 1'b1);
      read_cap(0, "R3 stopped counter");

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule